// File: doc/BRIEF.md
# Static Memory Write Cycle Sequencer

This block runs one write cycle at a time to an external asynchronous static memory on a single chip-select bank. The host presents a request with an address, write data, a transfer size and two 4-bit wait-state settings. The block accepts the request only while it is idle. It then drives the address and data, frames the cycle with chip select, and times the write enable and the active-low byte-lane strobes. When the cycle ends it pulses done and becomes ready again.

One setting sets the overall cycle length. The other sets how many clocks pass before write enable falls. A mode input chooses between two strobe styles. In the first, a common write enable is used and the byte lanes frame it. In the second, the byte lanes themselves act as per-byte write strobes and the common write enable stays high. The low two address bits pick the lanes for byte and halfword transfers.

Top module: `smw_write_seq`

## Requirements
- R1: After reset, chip select, write enable and every byte-lane strobe are high, done is low and ready is high.
- R2: A request is taken only when ready is high. A request made during a busy cycle is dropped: the address does not change, and no new cycle starts after the current one ends.
- R3: Chip select stays low for exactly max(len_ws, we_ws+1)+2 consecutive clocks, starting on the clock after the accepting edge.
- R4: With we_common_i=1, write enable falls we_ws+1 clocks after chip select falls and stays low for max(1, len_ws-we_ws) clocks.
- R5: Chip select falls at least one clock before write enable falls, and rises exactly one clock after write enable rises.
- R6: With we_common_i=1, the selected lanes fall we_ws clocks after chip select falls, which is one clock before write enable. They rise together with chip select, one clock after write enable rises.
- R7: With we_common_i=0, write enable stays high for the whole cycle, and the selected lanes are low in exactly the clocks where R4 would hold write enable low.
- R8: Lane i is bit i of mem_lane_n_o. size_i=2'b00 (byte) selects lane addr_i[1:0]. size_i=2'b01 (halfword) selects lanes 3:2 when addr_i[1]=1 and lanes 1:0 otherwise. size_i=2'b10 or 2'b11 (word) selects all four lanes. Lanes that are not selected stay high.
- R9: mem_addr_o and mem_data_o carry the accepted request's values from the first chip-select clock and do not change until chip select rises.
- R10: done_o is high for exactly one clock, the last clock of chip select low. ready_o is low for every chip-select-low clock and high when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Write request, taken when ready_o is high |
| ready_o | output | 1 | Block is idle and can take a request |
| addr_i | input | ADDR_W | Write address; bits 1:0 pick the byte lanes |
| data_i | input | DATA_W | Write data |
| size_i | input | 2 | Transfer size: 00 byte, 01 halfword, 10/11 word |
| len_ws_i | input | WS_W | Cycle-length wait-state setting |
| we_ws_i | input | WS_W | Clocks of delay before write enable |
| we_common_i | input | 1 | 1: common write enable; 0: lanes act as write strobes |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_lane_n_o | output | DATA_W/8 | Byte-lane strobes, active low |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_data_o | output | DATA_W | Memory write data bus |
| done_o | output | 1 | One-clock pulse on the cycle's last clock |

## Verification
The bench uses a fixed-seed random mix of wait-state pairs, sizes, offsets and both strobe modes. It checks the whole cycle clock by clock against a timing model. Directed cases cover the case where len_ws is at or below we_ws, which forces the one-clock stretched write-enable window. They also cover the all-zero and all-fifteen extremes, which show whether the length rule or the stretch rule is in effect. Halfword and byte transfers at every offset check the lane choice. Requests made mid-cycle check that a busy block drops them and does not start a queued cycle afterwards.

// File: rtl/smw_pkg.sv
// Shared definitions for the static memory write sequencer.
// Assumes a four-lane (32-bit) data path for the size encodings.
package smw_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WRD2 = 2'b11
    } xfer_size_e;
endpackage

// File: rtl/smw_lane_dec.sv
// Byte-lane select decoder: turns transfer size and low address bits
// into an active-high lane mask. Purely combinational.
// Assumes LANES is a power of two and at least 4.
module smw_lane_dec #(
    parameter int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] offset,
    output logic [LANES-1:0] mask
);
    import smw_pkg::*;

    xfer_size_e sz;
    assign sz = xfer_size_e'(size);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [OFF_W-1:0] LANE_IDX  = OFF_W'(i);
        localparam logic [OFF_W-1:0] HALF_BASE = OFF_W'(i & ~1);
        // one lane: pick by size
        always_comb begin
            unique case (sz)
                SZ_BYTE: mask[i] = (offset == LANE_IDX);
                SZ_HALF: mask[i] = ({offset[OFF_W-1:1], 1'b0} == HALF_BASE);
                default: mask[i] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/smw_timer.sv
// Cycle timer: counts clocks within a write cycle and produces the
// next-cycle phase flags (cycle active, lane frame, write window, last).
// Assumes start is only pulsed while idle; settings are sampled on start.
module smw_timer #(
    parameter int WS_W = 4,
    localparam int CNT_W = WS_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [WS_W-1:0] len_ws,
    input  logic [WS_W-1:0] we_ws,
    output logic            nxt_busy,
    output logic            nxt_frame,
    output logic            nxt_we_win,
    output logic            nxt_last
);
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] frm_beg_q, we_beg_q, we_end_q, last_q;
    logic [CNT_W-1:0] c_frm_beg, c_we_beg, c_we_end, c_last, c_lo_len;
    logic [CNT_W-1:0] s_frm_beg, s_we_beg, s_we_end, s_last;
    logic [CNT_W-1:0] nxt_cnt;

    // derive the phase boundaries from the incoming settings
    always_comb begin
        c_lo_len  = (len_ws > we_ws) ? CNT_W'(len_ws) - CNT_W'(we_ws) : CNT_W'(1);
        c_frm_beg = CNT_W'(we_ws);
        c_we_beg  = CNT_W'(we_ws) + CNT_W'(1);
        c_we_end  = CNT_W'(we_ws) + c_lo_len;
        c_last    = c_we_end + CNT_W'(1);
    end

    // choose fresh boundaries on start, stored ones otherwise
    always_comb begin
        s_frm_beg = start ? c_frm_beg : frm_beg_q;
        s_we_beg  = start ? c_we_beg  : we_beg_q;
        s_we_end  = start ? c_we_end  : we_end_q;
        s_last    = start ? c_last    : last_q;
    end

    // next counter value and next activity
    always_comb begin
        nxt_cnt  = start ? '0 : cnt_q + CNT_W'(1);
        nxt_busy = start | (busy_q & (cnt_q != last_q));
    end

    // phase flags for the coming clock
    always_comb begin
        nxt_frame  = nxt_busy && (nxt_cnt >= s_frm_beg);
        nxt_we_win = nxt_busy && (nxt_cnt >= s_we_beg) && (nxt_cnt <= s_we_end);
        nxt_last   = nxt_busy && (nxt_cnt == s_last);
    end

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            frm_beg_q <= '0;
            we_beg_q  <= '0;
            we_end_q  <= '0;
            last_q    <= '0;
        end else begin
            busy_q    <= nxt_busy;
            cnt_q     <= nxt_busy ? nxt_cnt : '0;
            frm_beg_q <= s_frm_beg;
            we_beg_q  <= s_we_beg;
            we_end_q  <= s_we_end;
            last_q    <= s_last;
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= last_q));
    // R4
    we_inside_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (we_end_q < last_q && we_beg_q <= we_end_q));
endmodule

// File: rtl/smw_write_seq.sv
// Static memory write sequencer top: accepts one write request while
// idle, then drives chip select, write enable, byte lanes, address and
// data with registered outputs, and pulses done on the last clock.
// Assumes a single bank and DATA_W a multiple of 32.
module smw_write_seq #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 32,
    parameter int WS_W   = 4,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    output logic              ready_o,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [1:0]        size_i,
    input  logic [WS_W-1:0]   len_ws_i,
    input  logic [WS_W-1:0]   we_ws_i,
    input  logic              we_common_i,
    output logic              mem_cs_n_o,
    output logic              mem_we_n_o,
    output logic [LANES-1:0]  mem_lane_n_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_data_o,
    output logic              done_o
);
    logic             start;
    logic             nxt_busy, nxt_frame, nxt_we_win, nxt_last;
    logic [LANES-1:0] dec_mask, mask_q, sel_mask;
    logic             mode_q, sel_mode;

    assign start = req_i & ready_o;

    smw_lane_dec #(.LANES(LANES)) i_lane_dec (
        .size   (size_i),
        .offset (addr_i[OFF_W-1:0]),
        .mask   (dec_mask)
    );

    smw_timer #(.WS_W(WS_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .len_ws     (len_ws_i),
        .we_ws      (we_ws_i),
        .nxt_busy   (nxt_busy),
        .nxt_frame  (nxt_frame),
        .nxt_we_win (nxt_we_win),
        .nxt_last   (nxt_last)
    );

    // pick request-time or held lane mask and strobe mode
    always_comb begin
        sel_mask = start ? dec_mask : mask_q;
        sel_mode = start ? we_common_i : mode_q;
    end

    // hold the request's lane mask and mode for the cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            mode_q <= 1'b1;
        end else if (start) begin
            mask_q <= dec_mask;
            mode_q <= we_common_i;
        end
    end

    // registered memory strobes and handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n_o   <= 1'b1;
            mem_we_n_o   <= 1'b1;
            mem_lane_n_o <= '1;
            done_o       <= 1'b0;
            ready_o      <= 1'b1;
        end else begin
            mem_cs_n_o   <= ~nxt_busy;
            mem_we_n_o   <= ~(sel_mode & nxt_we_win);
            mem_lane_n_o <= ~(sel_mask & {LANES{sel_mode ? nxt_frame : nxt_we_win}});
            done_o       <= nxt_last;
            ready_o      <= ~nxt_busy;
        end
    end

    // registered address and data, loaded on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o <= '0;
            mem_data_o <= '0;
        end else if (start) begin
            mem_addr_o <= addr_i;
            mem_data_o <= data_i;
        end
    end

    // R5
    cs_leads_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n_o) |-> $past(!mem_cs_n_o) && $past(mem_lane_n_o != '1));
    // R5
    cs_trails_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |=> $rose(mem_cs_n_o) && (mem_lane_n_o == '1));
    // R5
    we_within_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> !mem_cs_n_o);
    // R7
    we_idle_strobe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !mem_cs_n_o) |-> mem_we_n_o);
    // R8
    lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~mem_lane_n_o) == 0 || $countones(~mem_lane_n_o) == 1 ||
         $countones(~mem_lane_n_o) == 2 || $countones(~mem_lane_n_o) == LANES));
    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_data_o)));
    // R10
    done_ends_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (mem_cs_n_o && ready_o && !done_o));
    // R2
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cs_n_o |-> !ready_o);
endmodule

// File: tb/test_smw_write_seq.sv
module test_smw_write_seq;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 18;
    localparam int DATA_W = 32;
    localparam int WS_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_i;
    logic              ready_o;
    logic [ADDR_W-1:0] addr_i;
    logic [DATA_W-1:0] data_i;
    logic [1:0]        size_i;
    logic [WS_W-1:0]   len_ws_i;
    logic [WS_W-1:0]   we_ws_i;
    logic              we_common_i;
    logic              mem_cs_n_o;
    logic              mem_we_n_o;
    logic [3:0]        mem_lane_n_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_data_o;
    logic              done_o;

    int n_chk = 0;
    int n_err = 0;

    smw_write_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W)) i_smw_write_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .ready_o(ready_o),
        .addr_i(addr_i), .data_i(data_i), .size_i(size_i),
        .len_ws_i(len_ws_i), .we_ws_i(we_ws_i), .we_common_i(we_common_i),
        .mem_cs_n_o(mem_cs_n_o), .mem_we_n_o(mem_we_n_o), .mem_lane_n_o(mem_lane_n_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .done_o(done_o)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] exp_mask(input logic [1:0] sz, input logic [1:0] off);
        case (sz)
            2'b00:   return 4'b0001 << off;
            2'b01:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic int exp_len(input int lw, input int ww);
        return ((lw > ww + 1) ? lw : ww + 1) + 2;
    endfunction

    function automatic int exp_lo(input int lw, input int ww);
        return (lw > ww) ? lw - ww : 1;
    endfunction

    // one write cycle; inj >= 0 pulses a foreign request at that clock
    task automatic run_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                             input logic [1:0] sz, input int lw, input int ww,
                             input bit wc, input int inj);
        int n, lo, t;
        logic [3:0] m, lane_exp;
        bit we_on, frm_on;
        n  = exp_len(lw, ww);
        lo = exp_lo(lw, ww);
        m  = exp_mask(sz, a[1:0]);
        @(negedge clk);
        while (!ready_o) @(negedge clk);
        addr_i = a; data_i = d; size_i = sz;
        len_ws_i = WS_W'(lw); we_ws_i = WS_W'(ww); we_common_i = wc;
        req_i = 1'b1;
        @(negedge clk);
        t = 0;
        while (!mem_cs_n_o && t < 40) begin
            req_i = 1'b0;
            we_on  = (t >= ww + 1) && (t <= ww + lo);
            frm_on = (t >= ww);
            lane_exp = wc ? (frm_on ? ~m : 4'hF) : (we_on ? ~m : 4'hF);
            // R4 R7: write enable shape per mode
            chk(mem_we_n_o == !(wc && we_on), wc ? "R4 we_n" : "R7 we_n", mem_we_n_o, !(wc && we_on));
            // R6 R7 R8: lane strobes
            chk(mem_lane_n_o == lane_exp, wc ? "R6/R8 lanes" : "R7/R8 lanes", mem_lane_n_o, lane_exp);
            // R9: bus values held
            chk(mem_addr_o == a && mem_data_o == d, "R9 addr/data", mem_addr_o, a);
            // R10: done and ready inside the cycle
            chk(done_o == (t == n - 1) && !ready_o, "R10 done/ready", {done_o, ready_o}, {(t == n - 1), 1'b0});
            if (t == inj) begin
                req_i = 1'b1; addr_i = ~a; data_i = ~d;
            end
            @(negedge clk);
            t++;
        end
        req_i = 1'b0;
        // R3 R5: total chip-select clocks (cs rises one after the write window)
        chk(t == n, "R3 cycle length", t, n);
        chk(ready_o && !done_o && mem_lane_n_o == 4'hF && mem_we_n_o, "R10 idle after cycle",
            {ready_o, done_o}, 2'b10);
        if (inj >= 0) begin
            @(negedge clk);
            // R2: busy-time request dropped, nothing starts
            chk(mem_cs_n_o && ready_o && mem_addr_o == a, "R2 busy request dropped", mem_addr_o, a);
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C1));
        rst_n = 1'b0; req_i = 1'b0; addr_i = '0; data_i = '0; size_i = 2'b10;
        len_ws_i = '0; we_ws_i = '0; we_common_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset levels
        chk(mem_cs_n_o && mem_we_n_o && mem_lane_n_o == 4'hF && !done_o && ready_o,
            "R1 reset state", {mem_cs_n_o, mem_we_n_o, mem_lane_n_o, done_o, ready_o}, 8'b1111_1101);
        req_i = 1'b1;
        @(negedge clk);
        // R1: request held during reset is not taken
        chk(mem_cs_n_o, "R1 no cycle in reset", mem_cs_n_o, 1);
        req_i = 1'b0;
        rst_n = 1'b1;

        // directed corners
        run_write(18'h00000, 32'h11111111, 2'b10, 0, 0, 1'b1, -1);
        run_write(18'h3FFFF, 32'hDEADBEEF, 2'b10, 15, 0, 1'b1, -1);
        run_write(18'h12345, 32'hA5A5A5A5, 2'b00, 0, 15, 1'b1, -1);
        run_write(18'h00002, 32'h0BADF00D, 2'b01, 15, 15, 1'b0, -1);
        run_write(18'h00001, 32'h01020304, 2'b00, 5, 4, 1'b0, 2);
        run_write(18'h00003, 32'h55667788, 2'b00, 3, 7, 1'b1, 0);
        run_write(18'h00002, 32'h99AABBCC, 2'b00, 6, 2, 1'b1, -1);
        run_write(18'h00000, 32'hCAFEBABE, 2'b01, 8, 1, 1'b1, 5);
        run_write(18'h00003, 32'h0F0F0F0F, 2'b11, 2, 2, 1'b0, -1);

        // random mix
        for (int k = 0; k < 180; k++) begin
            int lw, ww, inj;
            lw  = int'($urandom_range(15, 0));
            ww  = int'($urandom_range(15, 0));
            inj = ($urandom_range(3, 0) == 0) ? int'($urandom_range(exp_len(lw, ww) - 1, 0)) : -1;
            run_write(ADDR_W'($urandom), $urandom, 2'($urandom), lw, ww, 1'($urandom), inj);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule